// File: doc/BRIEF.md
# Keyed Configuration Port Unlock

This block is the configuration front end of a peripheral controller. The host reaches it through two byte-wide locations on its bus: an index location and a data location. The index location names a configuration register, and the data location reads or writes that register. After reset the configuration space is sealed. While it is sealed, data reads return all ones and data writes are dropped.

The space opens only when the host writes a four-byte key to the index location with no other index write between the key bytes. The last key byte depends on which of two base addresses the port is strapped to. Once the space is open, the host can read the 16-bit chip identifier and the revision nibble. It can also pick a logical device, and for the monitoring device it can read and move that device's 16-bit I/O base. A base value of zero marks the monitoring device as disabled.

An exit command written to the control register seals the space again. The selected device and the programmed base survive the exit.

Top module: `key_cfg_port`

## Requirements
- R1: After reset the port is sealed (`unlocked`=0), the selected device number is 0x00, and `mon_base` holds MON_BASE_INIT (default 0x0290) with `mon_en`=1.
- R2: With `alt_sel`=0, four consecutive index writes of 0x87, 0x01, 0x55, 0x55 open the space, and `unlocked` is 1 after the edge of the fourth write.
- R3: With `alt_sel`=1 the fourth key byte is 0xAA. On that strap the sequence 0x87, 0x01, 0x55, 0x55 leaves the space sealed.
- R4: An index write that does not match the expected key byte returns the key matcher to its first step. The matcher does not resume where it stopped, and a repeated first byte also counts as a mismatch.
- R5: While sealed, a data-location read returns 0xFF and a data-location write changes no configuration register.
- R6: While open, register 0x20 reads the high byte of the chip ID and register 0x21 reads the low byte (defaults 0x87 and 0x12).
- R7: While open, register 0x22 reads the chip revision in bits 3:0, with bits 7:4 reading zero (default 0x08).
- R8: Register 0x07 holds the selected logical device number, and it is readable and writable while the space is open.
- R9: When the selected device is MON_LDN (default 0x04), register 0x60 is the high byte and register 0x61 is the low byte of `mon_base`. For any other device these indices read 0x00 and ignore writes. `mon_en` is 0 exactly when `mon_base` is zero.
- R10: A data write of 0x02 to register 0x02 seals the space. Any other value written to register 0x02 leaves it open.
- R11: An index write of any value while the space is open, 0xAA included, only loads the index and does not seal the space.
- R12: A read of the index location returns the current index while the space is open and 0xFF while it is sealed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_sel | input | 1 | Base-address strap: 0 primary, 1 alternate |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| addr | input | 1 | 0 selects the index location, 1 the data location |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the location selected by `addr` (combinational) |
| unlocked | output | 1 | Configuration space open |
| mon_base | output | 16 | Monitoring device I/O base |
| mon_en | output | 1 | Monitoring device enabled (base non-zero) |

## Verification
The assertions assume that the strap `alt_sel` stays constant while a key sequence is in progress. They also assume that every write is a single-cycle `wr_en` pulse whose `addr` and `wdata` are valid in that cycle. The bench changes the strap only while the port is sealed and the matcher is at its first step. It drives each write for exactly one clock, with inputs changed on the falling edge. Reads are sampled shortly after a falling edge, so the combinational read path has settled before the sample.

// File: rtl/key_cfg_port.sv
module key_cfg_port #(
  parameter logic [15:0] CHIP_ID       = 16'h8712,
  parameter logic [3:0]  CHIP_REV      = 4'h8,
  parameter logic [7:0]  MON_LDN       = 8'h04,
  parameter logic [15:0] MON_BASE_INIT = 16'h0290,
  parameter logic [7:0]  KEY0          = 8'h87,
  parameter logic [7:0]  KEY1          = 8'h01,
  parameter logic [7:0]  KEY2          = 8'h55,
  parameter logic [7:0]  KEY3_PRI      = 8'h55,
  parameter logic [7:0]  KEY3_ALT      = 8'hAA,
  parameter logic [7:0]  IDX_CTRL      = 8'h02,
  parameter logic [7:0]  EXIT_CMD      = 8'h02,
  parameter logic [7:0]  IDX_LDN       = 8'h07,
  parameter logic [7:0]  IDX_ID_HI     = 8'h20,
  parameter logic [7:0]  IDX_ID_LO     = 8'h21,
  parameter logic [7:0]  IDX_REV       = 8'h22,
  parameter logic [7:0]  IDX_BASE_HI   = 8'h60,
  parameter logic [7:0]  IDX_BASE_LO   = 8'h61
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alt_sel,
  input  logic        wr_en,
  input  logic        addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        unlocked,
  output logic [15:0] mon_base,
  output logic        mon_en
);

  logic [1:0] step;
  logic [7:0] idx;
  logic [7:0] ldn;
  logic [7:0] key_byte;

  wire wr_idx  = wr_en && !addr;
  wire wr_dat  = wr_en && addr && unlocked;
  wire mon_sel = (ldn == MON_LDN);

  always_comb begin
    case (step)
      2'd0:    key_byte = KEY0;
      2'd1:    key_byte = KEY1;
      2'd2:    key_byte = KEY2;
      default: key_byte = alt_sel ? KEY3_ALT : KEY3_PRI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step     <= 2'd0;
      unlocked <= 1'b0;
      idx      <= 8'h00;
      ldn      <= 8'h00;
      mon_base <= MON_BASE_INIT;
    end else begin
      if (wr_idx && !unlocked) begin
        if (wdata == key_byte) begin
          if (step == 2'd3) begin
            unlocked <= 1'b1;
            step     <= 2'd0;
          end else begin
            step <= step + 2'd1;
          end
        end else begin
          step <= 2'd0;
        end
      end
      if (wr_idx && unlocked) idx <= wdata;
      if (wr_dat) begin
        if (idx == IDX_CTRL && wdata == EXIT_CMD) unlocked <= 1'b0;
        if (idx == IDX_LDN) ldn <= wdata;
        if (mon_sel && idx == IDX_BASE_HI) mon_base[15:8] <= wdata;
        if (mon_sel && idx == IDX_BASE_LO) mon_base[7:0]  <= wdata;
      end
    end
  end

  always_comb begin
    if (!unlocked) begin
      rdata = 8'hFF;
    end else if (!addr) begin
      rdata = idx;
    end else begin
      case (idx)
        IDX_LDN:     rdata = ldn;
        IDX_ID_HI:   rdata = CHIP_ID[15:8];
        IDX_ID_LO:   rdata = CHIP_ID[7:0];
        IDX_REV:     rdata = {4'h0, CHIP_REV};
        IDX_BASE_HI: rdata = mon_sel ? mon_base[15:8] : 8'h00;
        IDX_BASE_LO: rdata = mon_sel ? mon_base[7:0] : 8'h00;
        default:     rdata = 8'h00;
      endcase
    end
  end

  assign mon_en = |mon_base;

endmodule

// File: rtl/key_cfg_port_chk.sv
module key_cfg_port_chk #(
  parameter logic [7:0] KEY3_PRI = 8'h55,
  parameter logic [7:0] KEY3_ALT = 8'hAA
) (
  input logic        clk,
  input logic        rst_n,
  input logic        alt_sel,
  input logic        wr_en,
  input logic        addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        unlocked,
  input logic [15:0] mon_base,
  input logic [7:0]  idx
);

  a_r5_sealed_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && addr) |-> (rdata == 8'hFF));

  a_r12_sealed_index_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !addr) |-> (rdata == 8'hFF));

  a_r5_base_frozen_sealed: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(mon_base));

  a_r2_open_needs_last_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en && !addr && wdata == (alt_sel ? KEY3_ALT : KEY3_PRI)));

  a_r10_exit_seals: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_en && addr && idx == 8'h02 && wdata == 8'h02) |=> !unlocked);

  a_r11_index_write_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_en && !addr) |=> unlocked);

  a_r10_only_exit_seals: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked) |-> $past(wr_en && addr && wdata == 8'h02));

endmodule

bind key_cfg_port key_cfg_port_chk u_chk (.*);

// File: tb/key_cfg_port_tb.sv
`timescale 1ns/1ps
module key_cfg_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        unlocked;
  logic [15:0] mon_base;
  logic        mon_en;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  key_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .alt_sel(alt_sel), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .unlocked(unlocked),
    .mon_base(mon_base), .mon_en(mon_en)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic key(input logic [7:0] k3);
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, k3);
  endtask

  task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
    wr(1'b0, i); rd(1'b1, d);
  endtask

  task automatic seal();
    wr(1'b0, 8'h02); wr(1'b1, 8'h02);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 unlocked", {15'd0, unlocked}, 16'd0);
    check("R1 base", mon_base, 16'h0290);
    check("R1 en", {15'd0, mon_en}, 16'd1);
    rd(1'b1, d); check("R5 sealed data read", {8'd0, d}, 16'h00FF);
    rd(1'b0, d); check("R12 sealed index read", {8'd0, d}, 16'h00FF);
  endtask

  task automatic t_sealed_write();
    logic [7:0] d;
    wr(1'b0, 8'h07); wr(1'b1, 8'h05);
    wr(1'b0, 8'h60); wr(1'b1, 8'h00);
    check("R5 base untouched", mon_base, 16'h0290);
    key(8'h55);
    check("R2 primary opens", {15'd0, unlocked}, 16'd1);
    reg_rd(8'h07, d); check("R1 R5 ldn zero", {8'd0, d}, 16'h0000);
  endtask

  task automatic t_ident();
    logic [7:0] d;
    reg_rd(8'h20, d); check("R6 id hi", {8'd0, d}, 16'h0087);
    reg_rd(8'h21, d); check("R6 id lo", {8'd0, d}, 16'h0012);
    reg_rd(8'h22, d); check("R7 rev", {8'd0, d}, 16'h0008);
    rd(1'b0, d); check("R12 index read", {8'd0, d}, 16'h0022);
    wr(1'b0, 8'hAA);
    check("R11 AA keeps open", {15'd0, unlocked}, 16'd1);
    rd(1'b0, d); check("R11 index AA", {8'd0, d}, 16'h00AA);
  endtask

  task automatic t_bank();
    logic [7:0] d;
    wr(1'b0, 8'h07); wr(1'b1, 8'h01);
    rd(1'b1, d); check("R8 ldn readback", {8'd0, d}, 16'h0001);
    reg_rd(8'h60, d); check("R9 other dev reads 0", {8'd0, d}, 16'h0000);
    wr(1'b1, 8'h12);
    check("R9 other dev ignores write", mon_base, 16'h0290);
    wr(1'b0, 8'h07); wr(1'b1, 8'h04);
    reg_rd(8'h60, d); check("R9 base hi", {8'd0, d}, 16'h0002);
    reg_rd(8'h61, d); check("R9 base lo", {8'd0, d}, 16'h0090);
    wr(1'b0, 8'h60); wr(1'b1, 8'h00);
    wr(1'b0, 8'h61); wr(1'b1, 8'h00);
    check("R9 base zero", mon_base, 16'h0000);
    check("R9 disabled", {15'd0, mon_en}, 16'd0);
    wr(1'b1, 8'h34);
    check("R9 base lo write", mon_base, 16'h0034);
    check("R9 enabled", {15'd0, mon_en}, 16'd1);
  endtask

  task automatic t_exit();
    logic [7:0] d;
    wr(1'b0, 8'h02); wr(1'b1, 8'h01);
    check("R10 other value keeps open", {15'd0, unlocked}, 16'd1);
    wr(1'b1, 8'h02);
    check("R10 exit seals", {15'd0, unlocked}, 16'd0);
    rd(1'b1, d); check("R5 after exit", {8'd0, d}, 16'h00FF);
  endtask

  task automatic t_broken();
    logic [7:0] d;
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h00); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    check("R4 broken key sealed", {15'd0, unlocked}, 16'd0);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    check("R4 repeated first byte sealed", {15'd0, unlocked}, 16'd0);
    key(8'h55);
    check("R4 clean key opens", {15'd0, unlocked}, 16'd1);
    reg_rd(8'h07, d); check("R8 ldn kept across exit", {8'd0, d}, 16'h0004);
    seal();
  endtask

  task automatic t_alt();
    @(negedge clk); alt_sel = 1'b1;
    key(8'h55);
    check("R3 primary key on alt", {15'd0, unlocked}, 16'd0);
    key(8'hAA);
    check("R3 alt key opens", {15'd0, unlocked}, 16'd1);
    check("R9 base kept", mon_base, 16'h0034);
    seal();
    check("R10 sealed again", {15'd0, unlocked}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sealed_write();
    t_ident();
    t_bank();
    t_exit();
    t_broken();
    t_alt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule